// File: doc/BRIEF.md
# Sequencer Transition Term Array

This block is the combinational next-state logic of a field-programmable Mealy sequencer. From sixteen external inputs, eight fed-back state bits and two complement signals it forms sixty-four product terms. In each term every literal can be required high, required low, or ignored. A fully programmable OR plane then connects any term to the J or the K input of any of sixteen registers: eight state bits and eight output bits. Because each register receives a J/K pair, the programmed terms can make a bit hold, set, clear or toggle.

Two complement arrays each take the NOR of a chosen set of terms. They return into the AND plane as extra literals, so that a single term can express the "none of the other transitions fired" branch. To keep the logic free of combinational loops, the value a term contributes to a complement array is formed from its input and state literals only.

The programming is presented as wide static configuration vectors. A separate mode input marks external input 5 as a second clock, which removes that input from every term. The registers, output tri-stating and device programming belong to the surrounding design.

Top module: `seq_transition_array`

## Requirements
- R1: With every configuration vector at zero, all J and K outputs are 0 and both complement outputs are 1, whatever the inputs.
- R2: A term with no literal fuse set is active, so a J or K input connected to it reads 1.
- R3: Literal l of term t has its high-requirement fuse at bit t*26+l of `fuse_true_i`. Literals 0 to 15 are `in_i`, 16 to 23 are `state_i` and 24 to 25 are `cmp_o`. With that fuse set, the term is active only while the literal is 1.
- R4: The low-requirement fuse sits at the same position in `fuse_comp_i`. With it set, the term is active only while the literal is 0.
- R5: When both fuses of the same literal are set, the term is inactive for either value of that literal.
- R6: Complement output c is 1 exactly when no term selected by bit c*64+t of `fuse_cmp_i` is active.
- R7: While `in5_clk_i` is 1, literal 5 has no effect on any term, whatever its fuses hold.
- R8: The J input of register r is the OR of the terms t whose bit r*64+t of `fuse_j_i` is set, and K is formed likewise from `fuse_k_i`. Registers 0 to 7 are `st_*_o` bits 0 to 7, and registers 8 to 15 are `out_*_o` bits 0 to 7.
- R9: One term may drive any number of J and K inputs at the same time.
- R10: The complement-literal fuses of a term play no part in that term's contribution to a complement array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | 16 | External inputs, literals 0 to 15 |
| state_i | input | 8 | State register feedback, literals 16 to 23 |
| in5_clk_i | input | 1 | Input 5 serves as a clock; its literal is ignored |
| fuse_true_i | input | 1664 | Per term and literal: require the literal high |
| fuse_comp_i | input | 1664 | Per term and literal: require the literal low |
| fuse_cmp_i | input | 128 | Per complement array and term: include the term in the NOR |
| fuse_j_i | input | 1024 | Per register and term: connect the term to J |
| fuse_k_i | input | 1024 | Per register and term: connect the term to K |
| st_j_o | output | 8 | J inputs of the state register bits |
| st_k_o | output | 8 | K inputs of the state register bits |
| out_j_o | output | 8 | J inputs of the output register bits |
| out_k_o | output | 8 | K inputs of the output register bits |
| cmp_o | output | 2 | Complement array outputs |

## Verification
The hardest situation to reach from the ports is a term whose result depends on a complement signal that is itself driven low by another term. Reaching it needs a chain of two programmed terms, and the first of them also carries a complement literal that must be ignored. Directed configurations build this chain explicitly and toggle the input that starts it. Sparse random fuse maps, in which each literal is set only rarely, then keep terms firing often enough that the complement arrays, the contradictory fuses and the fan-out to many registers all change state. Throughout, a behavioural model in the bench is compared against the outputs on every clock.

// File: rtl/seq_pkg.sv
// Package: shared sizes of the transition term array.
// Assumes literal order inputs, then state feedback, then complement signals.
package seq_pkg;
    localparam int IN_W     = 16;
    localparam int ST_W     = 8;
    localparam int OUT_W    = 8;
    localparam int TERM_N   = 64;
    localparam int CMP_N    = 2;
    localparam int CLK2_LIT = 5;
endpackage

// File: rtl/seq_term_and.sv
// Module: one product term of the AND plane.
// Evaluates the input/state literals (base_hit_o) and then the complement
// literals on top (hit_o). Assumes base_hit_o feeds the complement arrays,
// so it must never depend on cmp_i.
module seq_term_and #(
    parameter int BASE_N  = 24,
    parameter int CMP_N   = 2,
    parameter int CLK_LIT = 5,
    localparam int LIT_N  = BASE_N + CMP_N
) (
    input  logic [BASE_N-1:0] base_lit_i,
    input  logic [CMP_N-1:0]  cmp_i,
    input  logic [LIT_N-1:0]  fuse_t_i,
    input  logic [LIT_N-1:0]  fuse_c_i,
    input  logic              clk_lit_off_i,
    output logic              base_hit_o,
    output logic              hit_o
);
    logic [BASE_N-1:0] base_ok;
    logic [CMP_N-1:0]  cmp_ok;

    // Per-literal match over inputs and state; the clock literal may be masked
    for (genvar l = 0; l < BASE_N; l++) begin : g_base
        logic match;
        assign match = (~fuse_t_i[l] | base_lit_i[l]) & (~fuse_c_i[l] | ~base_lit_i[l]);
        if (l == CLK_LIT) begin : g_clk
            assign base_ok[l] = clk_lit_off_i | match;
        end else begin : g_plain
            assign base_ok[l] = match;
        end
    end

    // Per-literal match over the complement signals
    for (genvar c = 0; c < CMP_N; c++) begin : g_cmp
        assign cmp_ok[c] = (~fuse_t_i[BASE_N+c] | cmp_i[c])
                         & (~fuse_c_i[BASE_N+c] | ~cmp_i[c]);
    end

    // Term outputs: AND of all matched literals
    assign base_hit_o = &base_ok;
    assign hit_o      = base_hit_o & (&cmp_ok);
endmodule

// File: rtl/seq_cmp_array.sv
// Module: complement arrays, each the NOR of a programmed set of terms.
// Assumes term_i carries input/state-only term results (no feedback loop).
module seq_cmp_array #(
    parameter int TERM_N = 64,
    parameter int CMP_N  = 2
) (
    input  logic [TERM_N-1:0]       term_i,
    input  logic [CMP_N*TERM_N-1:0] fuse_sel_i,
    output logic [CMP_N-1:0]        cmp_o
);
    // One NOR per complement array
    for (genvar c = 0; c < CMP_N; c++) begin : g_nor
        assign cmp_o[c] = ~|(term_i & fuse_sel_i[c*TERM_N +: TERM_N]);
    end
endmodule

// File: rtl/seq_or_plane.sv
// Module: programmable OR plane feeding J and K of every register.
// Assumes row r of each fuse vector belongs to register r.
module seq_or_plane #(
    parameter int TERM_N = 64,
    parameter int REG_N  = 16
) (
    input  logic [TERM_N-1:0]       term_i,
    input  logic [REG_N*TERM_N-1:0] fuse_j_i,
    input  logic [REG_N*TERM_N-1:0] fuse_k_i,
    output logic [REG_N-1:0]        j_o,
    output logic [REG_N-1:0]        k_o
);
    // One OR gate per J and per K input
    for (genvar r = 0; r < REG_N; r++) begin : g_reg
        assign j_o[r] = |(term_i & fuse_j_i[r*TERM_N +: TERM_N]);
        assign k_o[r] = |(term_i & fuse_k_i[r*TERM_N +: TERM_N]);
    end
endmodule

// File: rtl/seq_transition_array.sv
// Module: top of the transition term array. It combines the AND plane,
// the complement arrays and the OR plane. Purely combinational; assumes the
// fuse vectors are static while the sequencer runs.
module seq_transition_array #(
    parameter int IN_W     = seq_pkg::IN_W,
    parameter int ST_W     = seq_pkg::ST_W,
    parameter int OUT_W    = seq_pkg::OUT_W,
    parameter int TERM_N   = seq_pkg::TERM_N,
    parameter int CMP_N    = seq_pkg::CMP_N,
    parameter int CLK2_LIT = seq_pkg::CLK2_LIT,
    localparam int BASE_N  = IN_W + ST_W,
    localparam int LIT_N   = BASE_N + CMP_N,
    localparam int REG_N   = ST_W + OUT_W
) (
    input  logic [IN_W-1:0]         in_i,
    input  logic [ST_W-1:0]         state_i,
    input  logic                    in5_clk_i,
    input  logic [TERM_N*LIT_N-1:0] fuse_true_i,
    input  logic [TERM_N*LIT_N-1:0] fuse_comp_i,
    input  logic [CMP_N*TERM_N-1:0] fuse_cmp_i,
    input  logic [REG_N*TERM_N-1:0] fuse_j_i,
    input  logic [REG_N*TERM_N-1:0] fuse_k_i,
    output logic [ST_W-1:0]         st_j_o,
    output logic [ST_W-1:0]         st_k_o,
    output logic [OUT_W-1:0]        out_j_o,
    output logic [OUT_W-1:0]        out_k_o,
    output logic [CMP_N-1:0]        cmp_o
);
    logic [BASE_N-1:0] base_lit;
    logic [TERM_N-1:0] base_hit;
    logic [TERM_N-1:0] term_hit;
    logic [CMP_N-1:0]  cmp_sig;
    logic [REG_N-1:0]  j_all;
    logic [REG_N-1:0]  k_all;

    // Literal bus: inputs in the low positions, state feedback above
    assign base_lit = {state_i, in_i};

    // AND plane: one instance per product term
    for (genvar t = 0; t < TERM_N; t++) begin : g_term
        seq_term_and #(
            .BASE_N (BASE_N),
            .CMP_N  (CMP_N),
            .CLK_LIT(CLK2_LIT)
        ) u_term (
            .base_lit_i   (base_lit),
            .cmp_i        (cmp_sig),
            .fuse_t_i     (fuse_true_i[t*LIT_N +: LIT_N]),
            .fuse_c_i     (fuse_comp_i[t*LIT_N +: LIT_N]),
            .clk_lit_off_i(in5_clk_i),
            .base_hit_o   (base_hit[t]),
            .hit_o        (term_hit[t])
        );
    end

    // Complement arrays over the input/state part of each term
    seq_cmp_array #(
        .TERM_N(TERM_N),
        .CMP_N (CMP_N)
    ) u_cmp (
        .term_i    (base_hit),
        .fuse_sel_i(fuse_cmp_i),
        .cmp_o     (cmp_sig)
    );

    // OR plane to all J/K inputs
    seq_or_plane #(
        .TERM_N(TERM_N),
        .REG_N (REG_N)
    ) u_or (
        .term_i  (term_hit),
        .fuse_j_i(fuse_j_i),
        .fuse_k_i(fuse_k_i),
        .j_o     (j_all),
        .k_o     (k_all)
    );

    // Split the register rows into the state and output groups
    assign st_j_o  = j_all[ST_W-1:0];
    assign st_k_o  = k_all[ST_W-1:0];
    assign out_j_o = j_all[REG_N-1:ST_W];
    assign out_k_o = k_all[REG_N-1:ST_W];
    assign cmp_o   = cmp_sig;
endmodule

// File: rtl/seq_transition_array_chk.sv
// Module: checker for the transition term array, bound to the top.
// The block has no clock, so the checks are immediate assertions on
// settled combinational values.
module seq_transition_array_chk #(
    parameter int TERM_N = 64,
    parameter int CMP_N  = 2,
    parameter int ST_W   = 8,
    parameter int OUT_W  = 8,
    parameter int LIT_N  = 26,
    localparam int REG_N = ST_W + OUT_W
) (
    input logic [TERM_N*LIT_N-1:0] fuse_true_i,
    input logic [TERM_N*LIT_N-1:0] fuse_comp_i,
    input logic [CMP_N*TERM_N-1:0] fuse_cmp_i,
    input logic [REG_N*TERM_N-1:0] fuse_j_i,
    input logic [REG_N*TERM_N-1:0] fuse_k_i,
    input logic [ST_W-1:0]         st_j_o,
    input logic [ST_W-1:0]         st_k_o,
    input logic [OUT_W-1:0]        out_j_o,
    input logic [OUT_W-1:0]        out_k_o,
    input logic [CMP_N-1:0]        cmp_o
);
    logic [REG_N-1:0] j_all;
    logic [REG_N-1:0] k_all;
    assign j_all = {out_j_o, st_j_o};
    assign k_all = {out_k_o, st_k_o};

    // Whole-array check for the unprogrammed fuse map
    always_comb begin
        if (fuse_true_i == '0 && fuse_comp_i == '0 && fuse_cmp_i == '0
            && fuse_j_i == '0 && fuse_k_i == '0) begin
            // R1
            virgin_idle_chk: assert (j_all == '0 && k_all == '0 && cmp_o == '1);
        end
    end

    // Per-register checks on empty OR rows
    for (genvar r = 0; r < REG_N; r++) begin : g_reg
        always_comb begin
            if (fuse_j_i[r*TERM_N +: TERM_N] == '0) begin
                // R8
                j_row_empty_chk: assert (j_all[r] == 1'b0);
            end
            if (fuse_k_i[r*TERM_N +: TERM_N] == '0) begin
                // R8
                k_row_empty_chk: assert (k_all[r] == 1'b0);
            end
        end
    end

    // Per-array check: an empty complement array reads 1
    for (genvar c = 0; c < CMP_N; c++) begin : g_cmp
        always_comb begin
            if (fuse_cmp_i[c*TERM_N +: TERM_N] == '0) begin
                // R6
                cmp_empty_chk: assert (cmp_o[c] == 1'b1);
            end
        end
    end
endmodule

bind seq_transition_array seq_transition_array_chk #(
    .TERM_N(TERM_N),
    .CMP_N (CMP_N),
    .ST_W  (ST_W),
    .OUT_W (OUT_W),
    .LIT_N (LIT_N)
) u_chk (
    .fuse_true_i(fuse_true_i),
    .fuse_comp_i(fuse_comp_i),
    .fuse_cmp_i (fuse_cmp_i),
    .fuse_j_i   (fuse_j_i),
    .fuse_k_i   (fuse_k_i),
    .st_j_o     (st_j_o),
    .st_k_o     (st_k_o),
    .out_j_o    (out_j_o),
    .out_k_o    (out_k_o),
    .cmp_o      (cmp_o)
);

// File: tb/seq_transition_array_tb_top.sv
// Bench: behavioural model compared on every clock, plus directed checks.
module seq_transition_array_tb_top;
    localparam int NT = 64;
    localparam int NL = 26;
    localparam int NR = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [15:0]      in_v = '0;
    logic [7:0]       st_v = '0;
    logic             clk5 = 1'b0;
    logic [NT*NL-1:0] f_t  = '0;
    logic [NT*NL-1:0] f_c  = '0;
    logic [2*NT-1:0]  f_s  = '0;
    logic [NR*NT-1:0] f_j  = '0;
    logic [NR*NT-1:0] f_k  = '0;
    logic [7:0] sj, sk, oj, ok;
    logic [1:0] cm;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    seq_transition_array dut_i (
        .in_i(in_v), .state_i(st_v), .in5_clk_i(clk5),
        .fuse_true_i(f_t), .fuse_comp_i(f_c), .fuse_cmp_i(f_s),
        .fuse_j_i(f_j), .fuse_k_i(f_k),
        .st_j_o(sj), .st_k_o(sk), .out_j_o(oj), .out_k_o(ok), .cmp_o(cm)
    );

    // Behavioural model: literal values, term results, NOR arrays, OR rows
    function automatic logic [33:0] model();
        bit lit [26];
        bit base [64];
        bit hit [64];
        bit cv [2];
        logic [15:0] jv, kv;
        for (int l = 0; l < 16; l++) lit[l] = in_v[l];
        for (int l = 0; l < 8; l++) lit[16+l] = st_v[l];
        for (int t = 0; t < NT; t++) begin
            base[t] = 1;
            for (int l = 0; l < 24; l++) begin
                if (clk5 && l == 5) continue;
                if (f_t[t*NL+l] && !lit[l]) base[t] = 0;
                if (f_c[t*NL+l] && lit[l]) base[t] = 0;
            end
        end
        for (int c = 0; c < 2; c++) begin
            cv[c] = 1;
            for (int t = 0; t < NT; t++) if (f_s[c*NT+t] && base[t]) cv[c] = 0;
        end
        for (int t = 0; t < NT; t++) begin
            hit[t] = base[t];
            for (int c = 0; c < 2; c++) begin
                if (f_t[t*NL+24+c] && !cv[c]) hit[t] = 0;
                if (f_c[t*NL+24+c] && cv[c]) hit[t] = 0;
            end
        end
        jv = '0; kv = '0;
        for (int r = 0; r < NR; r++)
            for (int t = 0; t < NT; t++) begin
                if (hit[t] && f_j[r*NT+t]) jv[r] = 1;
                if (hit[t] && f_k[r*NT+t]) kv[r] = 1;
            end
        return {cv[1], cv[0], kv[15:8], jv[15:8], kv[7:0], jv[7:0]};
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [33:0] e;
            e = model();
            checks++;
            if ({cm, ok, oj, sk, sj} !== e) begin
                errors++;
                $display("FAIL %s model: actual %h expected %h", cur_req, {cm, ok, oj, sk, sj}, e);
            end
        end
    end

    task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
        #1;
    endtask

    function automatic logic [33:0] outs();
        return {cm, ok, oj, sk, sj};
    endfunction

    task automatic clear_all();
        f_t = '0; f_c = '0; f_s = '0; f_j = '0; f_k = '0; clk5 = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cmp_en = 1'b1;
        // R1: unprogrammed map, several input patterns
        cur_req = "R1";
        for (int i = 0; i < 4; i++) begin
            in_v = 16'($urandom); st_v = 8'($urandom);
            step();
            chk("R1", outs(), {2'b11, 32'h0});
        end
        // R2: empty term drives state J0
        cur_req = "R2";
        f_j[0*NT+0] = 1;
        step();
        chk("R2", outs(), {2'b11, 32'h0000_0001});
        // R3: high fuse on input 3, term 1 to output K1 (register 9)
        cur_req = "R3";
        clear_all();
        f_t[1*NL+3] = 1; f_k[9*NT+1] = 1;
        in_v = 16'h0008; step(); chk("R3", {31'h0, ok[1]}, 32'h1);
        in_v = 16'hFFF7; step(); chk("R3", {31'h0, ok[1]}, 32'h0);
        // R4: low fuse on state bit 2 (literal 18), term 2 to output J7
        cur_req = "R4";
        clear_all();
        f_c[2*NL+18] = 1; f_j[15*NT+2] = 1;
        st_v = 8'h04; step(); chk("R4", {31'h0, oj[7]}, 32'h0);
        st_v = 8'hFB; step(); chk("R4", {31'h0, oj[7]}, 32'h1);
        // R5: contradictory fuses on input 0, term 3 to state K3
        cur_req = "R5";
        clear_all();
        f_t[3*NL+0] = 1; f_c[3*NL+0] = 1; f_k[3*NT+3] = 1;
        in_v = 16'h0001; step(); chk("R5", {31'h0, sk[3]}, 32'h0);
        in_v = 16'h0000; step(); chk("R5", {31'h0, sk[3]}, 32'h0);
        // R6/R10: term 4 (needs input 4, also carries cmp0 high fuse) feeds cmp0;
        // term 5 needs cmp0 high and drives state J5
        cur_req = "R6";
        clear_all();
        f_t[4*NL+4] = 1; f_t[4*NL+24] = 1; f_s[0*NT+4] = 1;
        f_t[5*NL+24] = 1; f_j[5*NT+5] = 1;
        in_v = 16'h0010; step();
        chk("R6", {30'h0, cm, sj[5]}, {30'h0, 2'b10, 1'b0});
        chk("R10", {31'h0, cm[0]}, 32'h0);
        in_v = 16'h0000; step();
        chk("R6", {30'h0, cm, sj[5]}, {30'h0, 2'b11, 1'b1});
        // R7: high fuse on input 5, term 6 to output K6
        cur_req = "R7";
        clear_all();
        f_t[6*NL+5] = 1; f_k[14*NT+6] = 1;
        in_v = 16'h0000; step(); chk("R7", {31'h0, ok[6]}, 32'h0);
        clk5 = 1; step(); chk("R7", {31'h0, ok[6]}, 32'h1);
        f_c[6*NL+5] = 1; in_v = 16'h0020; step(); chk("R7", {31'h0, ok[6]}, 32'h1);
        // R8/R9: term 7 (needs input 9) drives every J and K; term 8 adds to J0
        cur_req = "R9";
        clear_all();
        f_t[7*NL+9] = 1;
        for (int r = 0; r < NR; r++) begin f_j[r*NT+7] = 1; f_k[r*NT+7] = 1; end
        f_t[8*NL+10] = 1; f_j[0*NT+8] = 1;
        in_v = 16'h0200; step(); chk("R9", outs(), {2'b11, 32'hFFFF_FFFF});
        in_v = 16'h0400; step(); chk("R8", outs(), {2'b11, 32'h0000_0001});
        in_v = 16'h0000; step(); chk("R8", outs(), {2'b11, 32'h0});
        // R8: random sparse fuse maps, compared against the model each clock
        cur_req = "R8";
        for (int m = 0; m < 40; m++) begin
            clear_all();
            clk5 = ($urandom % 4) == 0;
            for (int t = 0; t < NT; t++) begin
                for (int l = 0; l < NL; l++) begin
                    if ($urandom % 20 == 0) f_t[t*NL+l] = 1;
                    if ($urandom % 20 == 0) f_c[t*NL+l] = 1;
                end
                for (int c = 0; c < 2; c++) if ($urandom % 12 == 0) f_s[c*NT+t] = 1;
                for (int r = 0; r < NR; r++) begin
                    if ($urandom % 10 == 0) f_j[r*NT+t] = 1;
                    if ($urandom % 10 == 0) f_k[r*NT+t] = 1;
                end
            end
            for (int i = 0; i < 50; i++) begin
                in_v = 16'($urandom); st_v = 8'($urandom);
                step();
            end
        end
        cmp_en = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule